// File: doc/BRIEF.md
# Character CRT Timing Controller

This block generates the raster timing for a character-mapped display. A host first loads a register index and then a data byte into a small register file. Every clock of the block is one character clock. On each one, a chain of counters moves through the characters of a scanline, the scanlines of a character row and the rows of a frame. From that chain the block produces a display-enable flag, a 14-bit refresh memory address, a 5-bit row address and simple horizontal and vertical sync pulses.

The refresh address advances only while characters are visible. Whenever a line ends, the address reloads from a stored line-start address. At the last scanline of a character row, that start address moves forward to the current refresh address, but only if the visible span actually closed inside the line. At the end of a frame, the start address reloads from the programmed base. Register writes are trimmed by a mask for each index, and only a narrow window of indices reads back.

Top module: `crtc_timing_core`

## Requirements
- R1: A write with `sel_we` stores the full 8-bit `wdata` as the selected index, with no truncation. For example, index 0x8C and index 0x1C both select no register (0x8C does not alias 12, and 0x1C does not alias 12).
- R2: A write with `data_we` updates register[index] only when index < 16. The stored value is `wdata` AND a mask. The mask is 0x7F for indices 4, 6, 7 and 10; 0x1F for 5, 9 and 11; 0x3F for 12 and 14; and 0xFF for the others. Writes to 16 and 17 are ignored, so those registers stay 0.
- R3: `rdata` shows the stored value of the selected register when the index is 12 to 17 inclusive, and 0xFF for every other index.
- R4: The character counter counts up by one per clock. A line ends in the clock where it equals register 0. The refresh address increments by one in every clock in which the character-visible flag is set, and holds otherwise.
- R5: In the clock where the character counter equals register 1, the character-visible flag clears from the next clock on. With register 1 below register 0, each line therefore shows register1+1 characters.
- R6: At the end of a line where the row address equals register 9 (5 bits), the row address becomes 0. In that case the line-start address takes the incremented refresh address only if the visible flag is clear after that clock. Otherwise the row address increments.
- R7: At every line end, the refresh address loads the (possibly new) line-start address, the character counter becomes 0 and the character-visible flag sets.
- R8: At a row end where the line counter equals register 4, the line counter becomes 0, the line-visible flag sets, and the line start and refresh address load {register12[5:0], register13}. At any other row end, the line counter increments, and the line-visible flag clears when the new count equals register 6.
- R9: `disp_en` is high exactly when both the character-visible and line-visible flags are set.
- R10: `hsync` is high for register3[3:0] clocks, starting the clock after the character counter equals register 2.
- R11: At a row end that moves the line counter to register 7, a vertical counter loads register3[7:4]. The counter decrements at every other line end, and `vsync` is high while it is nonzero.
- R12: After reset, all registers and the selected index are 0, all counters are 0, `ma` and `ra` are 0, both visible flags are set, and `hsync` and `vsync` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_we | input | 1 | Load `wdata` as register index |
| data_we | input | 1 | Write `wdata` to selected register |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data of selected register |
| disp_en | output | 1 | Display enable |
| ma | output | 14 | Refresh memory address |
| ra | output | 5 | Row (scanline within character row) address |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The register file is driven with a set of index/value vectors. Together they show which indices are writable, how each mask trims the value, and which indices read back. Indices above 15 are also used, to catch any truncation of the index to 4 or 5 bits. The timing chain is then checked clock by clock over a whole frame in two setups. In the first, the visible span ends before the line does, so the start address advances by the visible width on each row and the last row is blanked. In the second, the visible span never closes, so the address must not be re-latched and every row restarts at the frame base. A last frame with a changed base confirms that the base is reloaded at frame end.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_W     = 8;
  localparam int REG_COUNT = 18;
  localparam int WR_LIMIT  = 16;
  localparam int RD_LO     = 12;
  localparam int RD_HI     = 17;
  localparam int MA_W      = 14;
  localparam int RA_W      = 5;
  localparam int CNT_W     = 8;
  localparam int SYNC_W    = 4;

  // write mask applied to a data write, per register index
  function automatic logic [REG_W-1:0] wr_mask(input logic [REG_W-1:0] idx);
    case (idx)
      8'd4, 8'd6, 8'd7, 8'd10: wr_mask = 8'h7f;
      8'd5, 8'd9, 8'd11:       wr_mask = 8'h1f;
      8'd12, 8'd14:            wr_mask = 8'h3f;
      default:                 wr_mask = 8'hff;
    endcase
  endfunction

  function automatic logic rd_ok(input logic [REG_W-1:0] idx);
    rd_ok = (idx >= REG_W'(RD_LO)) && (idx <= REG_W'(RD_HI));
  endfunction

  function automatic logic [MA_W-1:0] ma_step(input logic [MA_W-1:0] a, input logic vis);
    ma_step = vis ? a + MA_W'(1) : a;
  endfunction

  function automatic logic [MA_W-1:0] frame_base(input logic [REG_W-1:0] hi, input logic [REG_W-1:0] lo);
    frame_base = {hi[MA_W-REG_W-1:0], lo};
  endfunction
endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
  import crtc_pkg::*;
#(
  parameter int NREG = REG_COUNT,
  parameter int NWR  = WR_LIMIT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_we,
  input  logic                       data_we,
  input  logic [REG_W-1:0]           wdata,
  output logic [REG_W-1:0]           sel_idx,
  output logic [NREG-1:0][REG_W-1:0] regs,
  output logic [REG_W-1:0]           rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_idx <= '0;
      regs    <= '0;
    end else begin
      if (sel_we) sel_idx <= wdata;
      if (data_we) begin
        for (int i = 0; i < NWR; i++) begin
          if (sel_idx == REG_W'(i)) regs[i] <= wdata & wr_mask(REG_W'(i));
        end
      end
    end
  end

  always_comb begin
    rdata = 8'hff;
    for (int i = RD_LO; i <= RD_HI; i++) begin
      if (i < NREG && sel_idx == REG_W'(i) && rd_ok(sel_idx)) rdata = regs[i];
    end
  end
endmodule

// File: rtl/crtc_hcount.sv
module crtc_hcount
  import crtc_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int HSW = SYNC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CW-1:0]  h_total,
  input  logic [CW-1:0]  h_disp,
  input  logic [CW-1:0]  hs_pos,
  input  logic [HSW-1:0] hs_width,
  output logic [CW-1:0]  hcnt,
  output logic           char_vis,
  output logic           eol,
  output logic           vis_end,
  output logic           vis_after,
  output logic           hsync
);
  logic [HSW-1:0] hs_cnt;

  assign eol       = (hcnt == h_total);
  assign vis_end   = (hcnt == h_disp);
  assign vis_after = char_vis && !vis_end;
  assign hsync     = (hs_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt     <= '0;
      char_vis <= 1'b1;
    end else if (eol) begin
      hcnt     <= '0;
      char_vis <= 1'b1;
    end else begin
      hcnt <= hcnt + CW'(1);
      if (vis_end) char_vis <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                hs_cnt <= '0;
    else if (hcnt == hs_pos)   hs_cnt <= hs_width;
    else if (hs_cnt != '0)     hs_cnt <= hs_cnt - HSW'(1);
  end
endmodule

// File: rtl/crtc_vcount.sv
module crtc_vcount
  import crtc_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int AW  = MA_W,
  parameter int RW  = RA_W,
  parameter int VSW = SYNC_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           eol,
  input  logic           char_vis,
  input  logic           vis_after,
  input  logic [RW-1:0]  row_last,
  input  logic [CW-1:0]  v_total,
  input  logic [CW-1:0]  v_disp,
  input  logic [CW-1:0]  vs_pos,
  input  logic [VSW-1:0] vs_width,
  input  logic [AW-1:0]  base_addr,
  output logic [AW-1:0]  ma,
  output logic [RW-1:0]  ra,
  output logic           line_vis,
  output logic           vsync,
  output logic           row_end,
  output logic           frame_end
);
  logic [CW-1:0]  vcnt;
  logic [AW-1:0]  line_start;
  logic [AW-1:0]  ma_inc;
  logic [CW-1:0]  vcnt_inc;
  logic [VSW-1:0] vs_cnt;

  assign ma_inc    = ma_step(ma, char_vis);
  assign vcnt_inc  = vcnt + CW'(1);
  assign row_end   = eol && (ra == row_last);
  assign frame_end = row_end && (vcnt == v_total);
  assign vsync     = (vs_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ma         <= '0;
      line_start <= '0;
      ra         <= '0;
      vcnt       <= '0;
      line_vis   <= 1'b1;
      vs_cnt     <= '0;
    end else if (!eol) begin
      ma <= ma_inc;
    end else begin
      if (vs_cnt != '0) vs_cnt <= vs_cnt - VSW'(1);
      if (!row_end) begin
        ra <= ra + RW'(1);
        ma <= line_start;
      end else begin
        ra <= '0;
        if (frame_end) begin
          vcnt       <= '0;
          line_vis   <= 1'b1;
          line_start <= base_addr;
          ma         <= base_addr;
        end else begin
          vcnt <= vcnt_inc;
          if (vcnt_inc == v_disp) line_vis <= 1'b0;
          if (vcnt_inc == vs_pos) vs_cnt <= vs_width;
          if (!vis_after) begin
            line_start <= ma_inc;
            ma         <= ma_inc;
          end else begin
            ma <= line_start;
          end
        end
      end
    end
  end
endmodule

// File: rtl/crtc_timing_core.sv
module crtc_timing_core
  import crtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we,
  input  logic             data_we,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             disp_en,
  output logic [13:0]      ma,
  output logic [4:0]       ra,
  output logic             hsync,
  output logic             vsync
);
  logic [REG_W-1:0]                sel_idx;
  logic [REG_COUNT-1:0][REG_W-1:0] regs;
  logic [CNT_W-1:0]                hcnt;
  logic                            char_vis, eol, vis_end, vis_after;
  logic                            line_vis, row_end, frame_end;
  logic [CNT_W-1:0]                h_total_w, h_disp_w;
  logic [RA_W-1:0]                 row_last_w;

  assign h_total_w  = regs[0];
  assign h_disp_w   = regs[1];
  assign row_last_w = regs[9][RA_W-1:0];

  crtc_regfile #(.NREG(REG_COUNT), .NWR(WR_LIMIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
    .wdata(wdata), .sel_idx(sel_idx), .regs(regs), .rdata(rdata)
  );

  crtc_hcount #(.CW(CNT_W), .HSW(SYNC_W)) u_h (
    .clk(clk), .rst_n(rst_n), .h_total(h_total_w), .h_disp(h_disp_w),
    .hs_pos(regs[2]), .hs_width(regs[3][SYNC_W-1:0]),
    .hcnt(hcnt), .char_vis(char_vis), .eol(eol), .vis_end(vis_end),
    .vis_after(vis_after), .hsync(hsync)
  );

  crtc_vcount #(.CW(CNT_W), .AW(MA_W), .RW(RA_W), .VSW(SYNC_W)) u_v (
    .clk(clk), .rst_n(rst_n), .eol(eol), .char_vis(char_vis),
    .vis_after(vis_after), .row_last(row_last_w), .v_total(regs[4]),
    .v_disp(regs[6]), .vs_pos(regs[7]), .vs_width(regs[3][7:4]),
    .base_addr(frame_base(regs[12], regs[13])),
    .ma(ma), .ra(ra), .line_vis(line_vis), .vsync(vsync),
    .row_end(row_end), .frame_end(frame_end)
  );

  assign disp_en = char_vis && line_vis;
endmodule

// File: rtl/crtc_checker.sv
module crtc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        sel_we,
  input logic [7:0]  wdata,
  input logic [7:0]  sel_idx,
  input logic [7:0]  rdata,
  input logic [7:0]  hcnt,
  input logic [7:0]  h_disp,
  input logic        char_vis,
  input logic        line_vis,
  input logic        eol,
  input logic [13:0] ma,
  input logic [4:0]  ra,
  input logic [4:0]  row_last,
  input logic        disp_en
);
  assert_idx_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_idx == $past(wdata));

  assert_rd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_idx < 8'd12 || sel_idx > 8'd17) |-> rdata == 8'hff);

  assert_ma_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vis && !eol) |=> ma == $past(ma) + 14'd1);

  assert_ma_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!char_vis && !eol) |=> $stable(ma));

  assert_vis_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == h_disp && !eol) |=> !char_vis);

  assert_row_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eol && ra == row_last) |=> ra == 5'd0);

  assert_line_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eol |=> (hcnt == 8'd0 && char_vis));

  assert_de_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (line_vis && char_vis));
endmodule

bind crtc_timing_core crtc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .wdata(wdata),
  .sel_idx(sel_idx), .rdata(rdata), .hcnt(hcnt), .h_disp(h_disp_w),
  .char_vis(char_vis), .line_vis(line_vis), .eol(eol), .ma(ma), .ra(ra),
  .row_last(row_last_w), .disp_en(disp_en)
);

// File: tb/tb_crtc_timing_core.sv
module tb_crtc_timing_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_we = 1'b0;
  logic        data_we = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        disp_en;
  logic [13:0] ma;
  logic [4:0]  ra;
  logic        hsync, vsync;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  crtc_timing_core dut (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .data_we(data_we),
    .wdata(wdata), .rdata(rdata), .disp_en(disp_en), .ma(ma), .ra(ra),
    .hsync(hsync), .vsync(vsync)
  );

  // {index, written value, expected readback}
  localparam logic [23:0] VEC [8] = '{
    {8'd12, 8'hff, 8'h3f}, {8'd13, 8'ha5, 8'ha5}, {8'd14, 8'hff, 8'h3f},
    {8'd15, 8'h5a, 8'h5a}, {8'd16, 8'h77, 8'h00}, {8'd17, 8'h77, 8'h00},
    {8'd4,  8'hff, 8'hff}, {8'd11, 8'hff, 8'hff}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put_idx(input logic [7:0] v);
    @(negedge clk); sel_we = 1'b1; wdata = v;
    @(negedge clk); sel_we = 1'b0;
  endtask

  task automatic put_dat(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic put_reg(input logic [7:0] idx, input logic [7:0] v);
    put_idx(idx); put_dat(v);
  endtask

  // wait for the vsync falling edge, then 16 clocks to the next frame start
  task automatic to_frame_start;
    logic prev;
    prev = vsync;
    forever begin
      @(negedge clk);
      if (prev && !vsync) break;
      prev = vsync;
    end
    repeat (16) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // vector table: masks (R2) and read window (R3)
    for (int i = 0; i < 8; i++) begin
      put_reg(VEC[i][23:16], VEC[i][15:8]);
      @(negedge clk);
      chk("R2 R3 readback", rdata, VEC[i][7:0]);
    end

    // R1: full index byte, no aliasing
    put_idx(8'h8c);
    @(negedge clk); chk("R1 idx 0x8C reads FF", rdata, 8'hff);
    put_dat(8'h00);
    put_idx(8'h1c); put_dat(8'h00);
    put_idx(8'd12);
    @(negedge clk); chk("R1 R2 reg12 untouched by high index", rdata, 8'h3f);

    // R12: reset state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 ma", ma, 0);
    chk("R12 ra", ra, 0);
    chk("R12 disp_en", disp_en, 1);
    chk("R12 hsync", hsync, 0);
    chk("R12 vsync", vsync, 0);
    chk("R12 idx0 reads FF", rdata, 8'hff);
    rst_n = 1'b1;
    put_idx(8'd13);
    @(negedge clk); chk("R12 reg13 cleared", rdata, 8'h00);

    // program: 8 chars/line, 5 visible, 2 scanlines/row, 3 rows, base 0x010
    put_reg(8'd13, 8'h10);
    put_reg(8'd4, 8'd2);
    put_reg(8'd9, 8'd1);
    put_reg(8'd0, 8'd7);
    put_reg(8'd1, 8'd4);
    put_reg(8'd2, 8'd5);
    put_reg(8'd3, 8'h22);
    put_reg(8'd6, 8'd2);
    put_reg(8'd7, 8'd1);

    to_frame_start();
    for (int v = 0; v < 3; v++)
      for (int r = 0; r < 2; r++)
        for (int h = 0; h < 8; h++) begin
          chk("R4 R6 R8 ma", ma, 'h10 + 5 * v + ((h < 5) ? h : 5));
          chk("R6 ra", ra, r);
          chk("R5 R9 disp_en", disp_en, (v < 2 && h <= 4) ? 1 : 0);
          chk("R10 hsync", hsync, (h >= 6) ? 1 : 0);
          chk("R11 vsync", vsync, (v == 1) ? 1 : 0);
          @(negedge clk);
        end
    chk("R8 wrap to base", ma, 'h10);

    // R6: visible span never closes -> no re-latch, every line restarts at base
    put_reg(8'd1, 8'd9);
    to_frame_start();
    for (int v = 0; v < 3; v++)
      for (int r = 0; r < 2; r++)
        for (int h = 0; h < 8; h++) begin
          chk("R6 R7 ma no latch", ma, 'h10 + h);
          chk("R9 disp_en", disp_en, (v < 2) ? 1 : 0);
          @(negedge clk);
        end

    // R8: new base picked up at frame end
    put_reg(8'd13, 8'h20);
    to_frame_start();
    chk("R8 new base", ma, 'h20);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule